// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to sixty-four interrupt request lines and drives one interrupt output toward a processor. Each line can be set to latch rising edges or to follow its level. Each line also carries a priority level and can be masked on its own. Software uses a 32-bit register bus. It reads a vector register to learn which source to service, and it writes an end-of-interrupt register when the service is complete.

Enable state changes only through paired registers for each 32-source half. One register of the pair sets bits and the other clears them, so no read-modify-write is needed. While a source is in service the output stays low. A vector value of 64 tells software that no valid source is available. A soft reset returns every controller register to zero. The output stays low until a global generation bit is set.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A write to ENA_LO (0x000) sets the enable of source n for every 1 in bit n; a write to ENA_HI (0x004) does the same for source 32+n. Reading either address returns that half's enable mask.
- R2: A write to DIS_LO (0x008) or DIS_HI (0x00C) clears the enable for every 1 bit in the same layout. Bits written as 0 leave the enable state unchanged.
- R3: Source n has a setup register at 0x100 + 8*n. Bit 7 selects the mode (1 is edge, 0 is level) and bits 3:0 hold the priority. It reads back as written, with all other bits zero.
- R4: An edge source latches a rising edge of its line as pending, and the latch holds after the line falls. A level source is pending only while its line is high.
- R5: Among sources that are pending and enabled, the highest priority wins. Equal priorities go to the lowest index.
- R6: A read of VECTOR (0x010) returns the index of the winning source and marks that source in service. It returns 64 when no source qualifies or when a source is already in service, and in that case it changes no state.
- R7: The output irq_out is high exactly when the generation bit is set, a qualifying source exists and nothing is in service.
- R8: A write of any value to EOI (0x014) ends the current service, so the next candidate can be delivered.
- R9: Writing 1 to bit 0 of RESET (0x01C) clears the enables, the setups, the edge latches, the generation bit and the in-service state.
- R10: An edge latch is cleared when its setup register is written with the mode bit changed. It is also cleared when its source is returned by a vector read.
- R11: Until bit 0 of GEN (0x018) is set, irq_out stays low, even if a qualifying source exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after bus_rd |
| irq_src | input | 64 | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Priority is tested with two sources at equal level and a third at lower level, which separates the tie-break by index from the level comparison. The level is then raised on the higher index to confirm that level comparison dominates. A one-cycle pulse on an edge source is compared with a held level source, which separates latching from sampling. The edge latch is then cleared in two ways, by acknowledge and by rewriting the mode, to show that each path clears it and that nothing else does. The enable and disable writes use mixed bit patterns and an all-zero write, which confirms that only 1 bits take effect.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned VEC_W   = 7;
  localparam int unsigned HALF_SZ = 32;
  localparam int unsigned MODE_BIT = 7;
  localparam logic [VEC_W-1:0] VEC_NONE = 7'd64;

  localparam logic [ADDR_W-1:0] A_ENA_LO = 12'h000;
  localparam logic [ADDR_W-1:0] A_ENA_HI = 12'h004;
  localparam logic [ADDR_W-1:0] A_DIS_LO = 12'h008;
  localparam logic [ADDR_W-1:0] A_DIS_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] A_VEC    = 12'h010;
  localparam logic [ADDR_W-1:0] A_EOI    = 12'h014;
  localparam logic [ADDR_W-1:0] A_GEN    = 12'h018;
  localparam logic [ADDR_W-1:0] A_RST    = 12'h01C;
  localparam logic [ADDR_W-1:0] A_SETUP  = 12'h100;
  localparam logic [ADDR_W-1:0] A_SETUP_END = 12'h300;

  // True when the address falls on one of the per-source setup slots.
  function automatic logic is_setup(input logic [ADDR_W-1:0] a);
    return (a >= A_SETUP) && (a < A_SETUP_END) && (a[2:0] == 3'b000);
  endfunction

  // Source index selected by a setup-slot address (8-byte stride).
  function automatic logic [5:0] setup_index(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - A_SETUP;
    return off[8:3];
  endfunction

  // A candidate replaces the running best only on a strictly higher level,
  // so an ascending scan keeps the lowest index among equals.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] cand,
                                      input logic [PRIO_W-1:0] best,
                                      input logic have_best);
    return !have_best || (cand > best);
  endfunction

  // Packs a setup register image for read-back.
  function automatic logic [BUS_W-1:0] setup_image(input logic mode_edge,
                                                   input logic [PRIO_W-1:0] lvl);
    logic [BUS_W-1:0] d;
    d = '0;
    d[MODE_BIT] = mode_edge;
    d[PRIO_W-1:0] = lvl;
    return d;
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [BUS_W-1:0]                bus_wdata,
  output logic [NUM_SRC-1:0]              en_mask,
  output logic [NUM_SRC-1:0]              edge_sel,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  output logic                            gen_en,
  output logic                            soft_rst,
  output logic                            eoi_wr,
  output logic [NUM_SRC-1:0]              mode_flip
);
  logic [NUM_SRC-1:0] en_set, en_clr, setup_hit;
  logic               setup_ok;
  logic [5:0]         setup_idx;

  assign setup_ok  = bus_wr && is_setup(bus_addr);
  assign setup_idx = setup_index(bus_addr);
  assign soft_rst  = bus_wr && (bus_addr == A_RST) && bus_wdata[0];
  assign eoi_wr    = bus_wr && (bus_addr == A_EOI);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned HALF = i / HALF_SZ;
    localparam int unsigned BITP = i % HALF_SZ;
    localparam logic [ADDR_W-1:0] A_SET = (HALF == 0) ? A_ENA_LO : A_ENA_HI;
    localparam logic [ADDR_W-1:0] A_CLR = (HALF == 0) ? A_DIS_LO : A_DIS_HI;

    assign en_set[i]    = bus_wr && (bus_addr == A_SET) && bus_wdata[BITP];
    assign en_clr[i]    = bus_wr && (bus_addr == A_CLR) && bus_wdata[BITP];
    assign setup_hit[i] = setup_ok && (setup_idx == 6'(i));
    assign mode_flip[i] = setup_hit[i] && (bus_wdata[MODE_BIT] != edge_sel[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_mask[i]  <= 1'b0;
        edge_sel[i] <= 1'b0;
        prio[i]     <= '0;
      end else if (soft_rst) begin
        en_mask[i]  <= 1'b0;
        edge_sel[i] <= 1'b0;
        prio[i]     <= '0;
      end else begin
        if (en_clr[i])      en_mask[i] <= 1'b0;
        else if (en_set[i]) en_mask[i] <= 1'b1;
        if (setup_hit[i]) begin
          edge_sel[i] <= bus_wdata[MODE_BIT];
          prio[i]     <= bus_wdata[PRIO_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             gen_en <= 1'b0;
    else if (soft_rst)                      gen_en <= 1'b0;
    else if (bus_wr && bus_addr == A_GEN)   gen_en <= bus_wdata[0];
  end
endmodule

// File: rtl/vic_src.sv
module vic_src
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] edge_sel,
  input  logic [NUM_SRC-1:0] ack_onehot,
  input  logic [NUM_SRC-1:0] mode_flip,
  input  logic               soft_rst,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] prev_q, latch_q, rise;

  assign rise = irq_src & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q <= irq_src;
      if (soft_rst) latch_q <= '0;
      else latch_q <= (latch_q & ~(ack_onehot | mode_flip)) | (rise & edge_sel);
    end
  end

  assign pending = (edge_sel & latch_q) | (~edge_sel & irq_src);
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]             pending,
  input  logic [NUM_SRC-1:0]             en_mask,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           cand_valid,
  output logic [VEC_W-1:0]               cand_idx,
  output logic [NUM_SRC-1:0]             cand_onehot
);
  logic [NUM_SRC-1:0] req;
  logic [PRIO_W-1:0]  best;

  assign req = pending & en_mask;

  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = VEC_NONE;
    best       = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && prio_beats(prio[i], best, cand_valid)) begin
        cand_valid = 1'b1;
        cand_idx   = VEC_W'(i);
        best       = prio[i];
      end
    end
    cand_onehot = '0;
    for (int i = 0; i < NUM_SRC; i++)
      cand_onehot[i] = cand_valid && (cand_idx == VEC_W'(i));
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic              irq_out
);
  localparam int unsigned HI_W = (NUM_SRC > HALF_SZ) ? NUM_SRC - HALF_SZ : 1;

  logic [NUM_SRC-1:0]             en_mask, edge_sel, mode_flip, pending;
  logic [NUM_SRC-1:0]             cand_onehot, ack_onehot;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic                           gen_en, soft_rst, eoi_wr, cand_valid;
  logic [VEC_W-1:0]               cand_idx, vec_val;
  logic                           in_svc, vec_rd, take;
  logic [BUS_W-1:0]               rd_mux;
  logic [5:0]                     rd_idx;

  vic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_mask(en_mask), .edge_sel(edge_sel),
    .prio(prio), .gen_en(gen_en), .soft_rst(soft_rst), .eoi_wr(eoi_wr),
    .mode_flip(mode_flip)
  );

  vic_src #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .edge_sel(edge_sel),
    .ack_onehot(ack_onehot), .mode_flip(mode_flip), .soft_rst(soft_rst),
    .pending(pending)
  );

  vic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pending(pending), .en_mask(en_mask), .prio(prio),
    .cand_valid(cand_valid), .cand_idx(cand_idx), .cand_onehot(cand_onehot)
  );

  // Acknowledge event: a vector read that hands out a real source.
  assign vec_rd     = bus_rd && (bus_addr == A_VEC);
  assign take       = vec_rd && !in_svc && cand_valid;
  assign ack_onehot = take ? cand_onehot : '0;
  assign vec_val    = (in_svc || !cand_valid) ? VEC_NONE : cand_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_svc <= 1'b0;
    else if (soft_rst) in_svc <= 1'b0;
    else if (take)     in_svc <= 1'b1;
    else if (eoi_wr)   in_svc <= 1'b0;
  end

  assign irq_out = gen_en && cand_valid && !in_svc;

  assign rd_idx = setup_index(bus_addr);

  always_comb begin
    rd_mux = '0;
    if (is_setup(bus_addr)) begin
      if (int'(rd_idx) < NUM_SRC) rd_mux = setup_image(edge_sel[rd_idx], prio[rd_idx]);
    end else begin
      case (bus_addr)
        A_ENA_LO: rd_mux = BUS_W'(en_mask[((NUM_SRC < HALF_SZ) ? NUM_SRC : HALF_SZ)-1:0]);
        A_ENA_HI: if (NUM_SRC > HALF_SZ) rd_mux = BUS_W'(en_mask[NUM_SRC-1 -: HI_W]);
        A_VEC:    rd_mux = BUS_W'(vec_val);
        A_GEN:    rd_mux = BUS_W'(gen_en);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take,
  input logic               eoi_wr,
  input logic               soft_rst,
  input logic               in_svc,
  input logic               irq_out,
  input logic               gen_en,
  input logic               vec_rd,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [NUM_SRC-1:0] ack_onehot
);
  p_take_marks_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !soft_rst |=> in_svc);

  p_busy_only_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc) |-> $past(vec_rd));

  p_eoi_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && !take |=> !in_svc);

  p_softrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en_mask == '0) && !gen_en && !in_svc);

  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_onehot));

  p_quiet_in_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc |-> !irq_out);

  p_needs_gen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !irq_out);
endmodule

bind vec_irq_ctrl vic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .eoi_wr(eoi_wr), .soft_rst(soft_rst),
  .in_svc(in_svc), .irq_out(irq_out), .gen_en(gen_en), .vec_rd(vec_rd),
  .en_mask(en_mask), .ack_onehot(ack_onehot)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src = '0;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out)
  );

  function automatic logic [11:0] setup_at(input int n);
    return 12'h100 + 12'(n * 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R7 out low after reset", 32'(irq_out), 0);
    rd(12'h010, d); chk("R6 empty vector", d, 64);
    rd(12'h000, d); chk("R1 enables clear", d, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(12'h000, 32'h0000_00F0);
    rd(12'h000, d); chk("R1 set low half", d, 32'h0000_00F0);
    wr(12'h004, 32'h8000_0001);
    rd(12'h004, d); chk("R1 set high half", d, 32'h8000_0001);
    wr(12'h008, 32'h0000_0030);
    rd(12'h000, d); chk("R2 clear selected", d, 32'h0000_00C0);
    wr(12'h008, 32'h0);
    rd(12'h000, d); chk("R2 zero write no effect", d, 32'h0000_00C0);
    wr(12'h008, 32'hFFFF_FFFF); wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 clear high half", d, 0);
  endtask

  task automatic t_setup();
    logic [31:0] d;
    wr(setup_at(5), 32'hFFFF_FF83);
    rd(setup_at(5), d); chk("R3 setup 5 readback", d, 32'h83);
    wr(setup_at(63), 32'h0A);
    rd(setup_at(63), d); chk("R3 setup 63 readback", d, 32'h0A);
  endtask

  task automatic t_level_gen();
    wr(12'h004, 32'h8000_0000);
    irq_src[63] = 1'b1; idle(2);
    chk("R11 gated while gen off", 32'(irq_out), 0);
    wr(12'h018, 32'h1); idle(1);
    chk("R7 out with gen on", 32'(irq_out), 1);
    irq_src[63] = 1'b0; idle(1);
    chk("R4 level follows line", 32'(irq_out), 0);
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    wr(12'h000, 32'h0000_0020);
    irq_src[5] = 1'b1; idle(1); irq_src[5] = 1'b0; idle(2);
    chk("R4 edge latched", 32'(irq_out), 1);
    rd(12'h010, d); chk("R6 vector edge src", d, 5);
    chk("R7 quiet in service", 32'(irq_out), 0);
    rd(12'h010, d); chk("R6 busy gives 64", d, 64);
    wr(12'h014, 32'h1234); idle(1);
    chk("R10 ack consumed latch", 32'(irq_out), 0);
  endtask

  task automatic t_mode_clear();
    logic [31:0] d;
    irq_src[5] = 1'b1; idle(1); irq_src[5] = 1'b0; idle(1);
    chk("R4 edge relatched", 32'(irq_out), 1);
    wr(setup_at(5), 32'h03); wr(setup_at(5), 32'h83); idle(1);
    chk("R10 mode rewrite clears", 32'(irq_out), 0);
    rd(12'h010, d); chk("R10 nothing left", d, 64);
    wr(12'h008, 32'h0000_0020);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(setup_at(10), 32'h2); wr(setup_at(20), 32'h2); wr(setup_at(40), 32'h1);
    wr(12'h000, 32'h0010_0400); wr(12'h004, 32'h0000_0100);
    irq_src[10] = 1'b1; irq_src[20] = 1'b1; irq_src[40] = 1'b1; idle(1);
    rd(12'h010, d); chk("R5 tie to lowest index", d, 10);
    wr(12'h014, 32'h0); idle(1);
    chk("R8 eoi re-raises", 32'(irq_out), 1);
    wr(setup_at(20), 32'h5);
    rd(12'h010, d); chk("R5 higher level wins", d, 20);
    wr(12'h014, 32'h0);
    wr(12'h008, 32'h0010_0400);
    rd(12'h010, d); chk("R2 masked sources skipped", d, 40);
    wr(12'h014, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    rd(12'h010, d); chk("R6 pre-reset take", d, 40);
    wr(12'h01C, 32'h1); idle(1);
    chk("R9 out low after soft reset", 32'(irq_out), 0);
    rd(12'h004, d); chk("R9 enables zero", d, 0);
    rd(setup_at(20), d); chk("R9 setup zero", d, 0);
    rd(12'h018, d); chk("R9 gen zero", d, 0);
    wr(12'h018, 32'h1); wr(12'h004, 32'h0000_0100); idle(1);
    chk("R9 in-service cleared", 32'(irq_out), 1);
    irq_src = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_enables();
    t_setup();
    t_level_gen();
    t_edge_ack();
    t_mode_clear();
    t_priority();
    t_soft_reset();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule